// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the software-visible register file of an interrupt redirection unit. It sits on a memory-mapped bus with three offsets. A select register chooses one word of an internal register space. A data window reads or writes the chosen word. A separate write-only end-of-interrupt port is also decoded. The internal space holds an identification word, a read-only version word, an arbitration word and a table of 64-bit redirection entries, one per interrupt pin. Each entry is reached as two 32-bit halves.

The delivery engine, which is outside this block, owns two status bits in every entry: delivery status and remote request pending. It drives them through dedicated inputs, and software writes never overwrite them. The engine sees every entry at all times on a flat output vector. It receives a one-cycle service request after every accepted entry write. It also receives a one-cycle end-of-interrupt pulse carrying a vector when software writes the end-of-interrupt port. That port works only in the newer version setting.

Bus accesses take one cycle. Writes take effect at the clock edge where they are presented. Read data and its valid flag are registered and appear one cycle after the request.

Top module: `intredir_regs`

## Requirements
- R1: The block decodes only bus address bits 7:0. The select register is at offset 0x00, the data window at 0x10 and the end-of-interrupt port at 0x40, and higher address bits alias onto the same registers.
- R2: A data-window access with `bus_word` low is a narrow access. A narrow read returns 0, and a narrow write changes no register and raises no service request.
- R3: Select value 0x00 is the identification register, which holds a 4-bit ID in bits 27:24. Writes keep only those bits, and reads return the ID there with all other bits 0. Select value 0x02 reads the same word as 0x00. Writes to 0x01 and 0x02 are ignored.
- R4: Select value 0x01 reads as the VERSION parameter in bits 7:0 and the pin count minus one in bits 23:16, with all other bits 0. VERSION must be 0x11 or 0x20, and the default is 0x20.
- R5: For select values from 0x10 upward, the entry index is (select − 0x10) >> 1. An even select reaches bits 31:0 and an odd select reaches bits 63:32. Indexes at or beyond the pin count, and select values 0x03–0x0F, read as 0 and ignore writes. An entry that is not written keeps all its software bits.
- R6: Entry bit 12 (delivery status) follows `eng_dstat` and bit 13 (remote pending) is set by `eng_rirr_set` and cleared by `eng_rirr_clr`. An entry write never changes either bit from the written data. Every other entry bit takes the written data.
- R7: After an entry write, if bit 15 (trigger mode, 1 = level) of the resulting entry is 0, bit 13 is forced to 0. Bit 14 is the polarity, bits 10:8 the delivery mode and bit 16 the mask.
- R8: A 32-bit write to the end-of-interrupt port produces a one-cycle `eoi_valid` with `eoi_vector` equal to write data bits 7:0, on the cycle after the write. This happens only when VERSION is 0x20. A narrow write to the port, or any write to it when VERSION is 0x11, produces no pulse.
- R9: Every accepted entry write, in range and 32 bits wide, produces a one-cycle `svc_req` on the cycle after the write. Writes to other registers produce none.
- R10: After reset, every entry is 0x0000_0000_0001_0000 (masked, all else 0), and the select register and ID are 0.
- R11: `entries_flat[64*i +: 64]` always shows entry i.
- R12: The select register holds 8 bits, written from data bits 7:0, and reads back at offset 0x00 with upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits 7:0 decoded |
| bus_word | input | 1 | 1 = full 32-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned (one cycle after request) |
| eng_rirr_set | input | NUM_PINS | Per-pin set of remote pending bit |
| eng_rirr_clr | input | NUM_PINS | Per-pin clear of remote pending bit (wins over set) |
| eng_dstat | input | NUM_PINS | Per-pin delivery status level |
| svc_req | output | 1 | Pulse after an accepted entry write |
| eoi_valid | output | 1 | End-of-interrupt pulse |
| eoi_vector | output | 8 | Vector carried with eoi_valid |
| entries_flat | output | 64*NUM_PINS | All redirection entries |

## Verification
The bench builds the block with the default 24 pins and a 12-bit address. It adds a second copy with VERSION set to 0x11, which shares the same bus. With 24 pins the whole select space can be swept. That covers every half of every entry, the first out-of-range index 24 at select 0x40, and every select value up to 0xFF, with expected entry contents computed from the write-merge rule. The second copy shows the version-dependent behaviour side by side with the first: its version word, and the absence of end-of-interrupt pulses for identical writes.

// File: rtl/intredir_pkg.sv
// Package: shared offsets, select codes and entry bit positions for the
// interrupt redirection register window.
package intredir_pkg;

    // Bus offsets (address bits 7:0)
    localparam logic [7:0] OFF_SELECT = 8'h00;
    localparam logic [7:0] OFF_WINDOW = 8'h10;
    localparam logic [7:0] OFF_EOI    = 8'h40;

    // Select codes of the internal register space
    localparam logic [7:0] SEL_IDENT    = 8'h00;
    localparam logic [7:0] SEL_VERSION  = 8'h01;
    localparam logic [7:0] SEL_ARBIT    = 8'h02;
    localparam logic [7:0] SEL_TBL_BASE = 8'h10;

    // Redirection entry bit positions
    localparam int B_DSTAT = 12;
    localparam int B_RIRR  = 13;
    localparam int B_POL   = 14;
    localparam int B_TRIG  = 15;
    localparam int B_MASK  = 16;

    // Identification and version word fields
    localparam int ID_LSB     = 24;
    localparam int ID_W       = 4;
    localparam int MAXENT_LSB = 16;

    // Version setting that owns the end-of-interrupt port
    localparam logic [7:0] VER_WITH_EOI = 8'h20;

    // Entry value after reset: masked, everything else clear
    localparam logic [63:0] ENTRY_RESET = 64'h1 << B_MASK;

    // Decoded table-access descriptor
    typedef struct packed {
        logic       hit;   // select falls on an existing entry
        logic [6:0] idx;   // entry index
        logic       hi;    // upper half selected
    } tbl_sel_t;

endpackage

// File: rtl/intredir_decode.sv
// Module: intredir_decode
// Decodes bus accesses into the select register, the identification
// register, entry write strobes and the end-of-interrupt pulse.
// Assumes one access per cycle; only address bits 7:0 are meaningful.
module intredir_decode
    import intredir_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          ADDR_W   = 12,
    parameter logic [7:0]  VERSION  = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_word,
    input  logic [31:0]       bus_wdata,
    output logic [7:0]        sel_q,
    output logic [ID_W-1:0]   id_q,
    output tbl_sel_t          tsel,
    output logic              tbl_wr,
    output logic              rd_req,
    output logic              rd_is_sel,
    output logic              rd_is_win,
    output logic              svc_req,
    output logic              eoi_valid,
    output logic [7:0]        eoi_vector
);

    localparam logic       EOI_EN   = (VERSION == VER_WITH_EOI);
    localparam logic [6:0] NPINS_7  = 7'(NUM_PINS);

    logic [7:0] off;
    logic       hit_sel, hit_win, hit_eoi;
    logic       win_wr;
    logic [7:0] rel;
    logic       unused_bits;

    // Upper address and data bits that no register keeps
    assign unused_bits = ^{bus_addr, bus_wdata};

    // Offset decode on the low address byte only
    always_comb begin
        off     = bus_addr[7:0];
        hit_sel = (off == OFF_SELECT);
        hit_win = (off == OFF_WINDOW);
        hit_eoi = (off == OFF_EOI);
        win_wr  = bus_valid && bus_write && hit_win && bus_word;
    end

    // Translate the select value into a table index and half
    always_comb begin
        rel      = sel_q - SEL_TBL_BASE;
        tsel.idx = rel[7:1];
        tsel.hi  = sel_q[0];
        tsel.hit = (sel_q >= SEL_TBL_BASE) && (rel[7:1] < NPINS_7);
    end

    assign tbl_wr    = win_wr && tsel.hit;
    assign rd_req    = bus_valid && !bus_write;
    assign rd_is_sel = hit_sel;
    assign rd_is_win = hit_win && bus_word;

    // Select register: any-width write at the select offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= 8'h00;
        else if (bus_valid && bus_write && hit_sel)
            sel_q <= bus_wdata[7:0];
    end

    // Identification register: full-width window write with ID selected
    always_ff @(posedge clk) begin
        if (!rst_n)
            id_q <= '0;
        else if (win_wr && (sel_q == SEL_IDENT))
            id_q <= bus_wdata[ID_LSB +: ID_W];
    end

    // Service request one cycle after an accepted entry write
    always_ff @(posedge clk) begin
        if (!rst_n)
            svc_req <= 1'b0;
        else
            svc_req <= tbl_wr;
    end

    // End-of-interrupt pulse, present only in the version that owns it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_valid  <= 1'b0;
            eoi_vector <= 8'h00;
        end else begin
            eoi_valid <= EOI_EN && bus_valid && bus_write && hit_eoi && bus_word;
            if (EOI_EN && bus_valid && bus_write && hit_eoi && bus_word)
                eoi_vector <= bus_wdata[7:0];
        end
    end

    AST_EOI_NEEDS_WORD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_valid && bus_write && bus_word && (bus_addr[7:0] == OFF_EOI))); // R8

    AST_SVC_NEEDS_WINDOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> $past(bus_valid && bus_write && bus_word && (bus_addr[7:0] == OFF_WINDOW))); // R9

    AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && (bus_addr[7:0] == OFF_SELECT)) |=> $stable(sel_q)); // R12

endmodule

// File: rtl/intredir_entry.sv
// Module: intredir_entry
// One 64-bit redirection entry. Software writes one 32-bit half at a
// time; the delivery-status and remote-pending bits are owned by the
// delivery engine and survive every software write. A write that leaves
// the entry in edge mode forces remote-pending to 0.
// Assumes wr_lo and wr_hi are never both high.
module intredir_entry
    import intredir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rirr_set,
    input  logic        rirr_clr,
    input  logic        dstat_in,
    output logic [63:0] entry_q
);

    logic [63:0] merged;
    logic        rirr_nxt;

    // Merge written half, then rebuild the engine-owned status bits
    always_comb begin
        merged = entry_q;
        if (wr_lo)
            merged[31:0] = wdata;
        if (wr_hi)
            merged[63:32] = wdata;
        rirr_nxt = (entry_q[B_RIRR] || rirr_set) && !rirr_clr;
        if ((wr_lo || wr_hi) && !merged[B_TRIG])
            rirr_nxt = 1'b0;
        merged[B_RIRR]  = rirr_nxt;
        merged[B_DSTAT] = dstat_in;
    end

    // Entry storage
    always_ff @(posedge clk) begin
        if (!rst_n)
            entry_q <= ENTRY_RESET;
        else
            entry_q <= merged;
    end

    AST_RIRR_KEPT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && wdata[B_TRIG] && !rirr_set && !rirr_clr) |=> (entry_q[B_RIRR] == $past(entry_q[B_RIRR]))); // R6

    AST_EDGE_WRITE_CLEARS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wdata[B_TRIG]) |=> !entry_q[B_RIRR]); // R7

    AST_UNWRITTEN_ENTRY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo && !wr_hi) |=> ($stable(entry_q[63:14]) && $stable(entry_q[11:0]))); // R5

endmodule

// File: rtl/intredir_rdmux.sv
// Module: intredir_rdmux
// Selects the read word for the select offset or the data window and
// registers it. Narrow window reads, unknown select codes and table
// indexes beyond the pin count return 0.
module intredir_rdmux
    import intredir_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter logic [7:0]  VERSION  = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rd_req,
    input  logic                   rd_is_sel,
    input  logic                   rd_is_win,
    input  logic [7:0]             sel_q,
    input  logic [ID_W-1:0]        id_q,
    input  tbl_sel_t               tsel,
    input  logic [64*NUM_PINS-1:0] entries_flat,
    output logic [31:0]            rdata,
    output logic                   rvalid
);

    localparam logic [7:0]  MAXENT   = 8'(NUM_PINS - 1);
    localparam logic [31:0] VER_WORD = (32'(MAXENT) << MAXENT_LSB) | 32'(VERSION);

    logic [63:0] pick;
    logic [31:0] win_word;
    logic [31:0] nxt;

    // Pick the addressed entry
    always_comb begin
        pick = '0;
        for (int k = 0; k < NUM_PINS; k++)
            if (tsel.idx == 7'(k))
                pick = entries_flat[64*k +: 64];
    end

    // Window word by select code
    always_comb begin
        if (sel_q == SEL_IDENT || sel_q == SEL_ARBIT)
            win_word = 32'(id_q) << ID_LSB;
        else if (sel_q == SEL_VERSION)
            win_word = VER_WORD;
        else if (tsel.hit)
            win_word = tsel.hi ? pick[63:32] : pick[31:0];
        else
            win_word = 32'h0;
    end

    // Offset-level read choice
    always_comb begin
        if (rd_is_sel)
            nxt = {24'h0, sel_q};
        else if (rd_is_win)
            nxt = win_word;
        else
            nxt = 32'h0;
    end

    // Registered read return
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= 32'h0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_req;
            if (rd_req)
                rdata <= nxt;
        end
    end

    AST_NARROW_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_is_sel && !rd_is_win) |=> (rvalid && rdata == 32'h0)); // R2

endmodule

// File: rtl/intredir_regs.sv
// Module: intredir_regs (top)
// Indirect register window for interrupt redirection entries: a select
// register, a data window and an end-of-interrupt port. Instantiates the
// decoder, one entry per pin and the read multiplexer.
// Assumes VERSION is 0x11 or 0x20 and NUM_PINS is 1..64.
module intredir_regs
    import intredir_pkg::*;
#(
    parameter int          NUM_PINS = 24,
    parameter int          ADDR_W   = 12,
    parameter logic [7:0]  VERSION  = 8'h20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_word,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   bus_rvalid,
    input  logic [NUM_PINS-1:0]    eng_rirr_set,
    input  logic [NUM_PINS-1:0]    eng_rirr_clr,
    input  logic [NUM_PINS-1:0]    eng_dstat,
    output logic                   svc_req,
    output logic                   eoi_valid,
    output logic [7:0]             eoi_vector,
    output logic [64*NUM_PINS-1:0] entries_flat
);

    logic [7:0]      sel_q;
    logic [ID_W-1:0] id_q;
    tbl_sel_t        tsel;
    logic            tbl_wr;
    logic            rd_req, rd_is_sel, rd_is_win;

    initial begin
        AST_VERSION_LEGAL: assert (VERSION == 8'h11 || VERSION == 8'h20); // R4
    end

    intredir_decode #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .VERSION  (VERSION)
    ) decode_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_word   (bus_word),
        .bus_wdata  (bus_wdata),
        .sel_q      (sel_q),
        .id_q       (id_q),
        .tsel       (tsel),
        .tbl_wr     (tbl_wr),
        .rd_req     (rd_req),
        .rd_is_sel  (rd_is_sel),
        .rd_is_win  (rd_is_win),
        .svc_req    (svc_req),
        .eoi_valid  (eoi_valid),
        .eoi_vector (eoi_vector)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_entry
        logic wr_lo_g, wr_hi_g;

        // Per-entry half strobes
        always_comb begin
            wr_lo_g = tbl_wr && (tsel.idx == 7'(g)) && !tsel.hi;
            wr_hi_g = tbl_wr && (tsel.idx == 7'(g)) &&  tsel.hi;
        end

        intredir_entry entry_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_lo    (wr_lo_g),
            .wr_hi    (wr_hi_g),
            .wdata    (bus_wdata),
            .rirr_set (eng_rirr_set[g]),
            .rirr_clr (eng_rirr_clr[g]),
            .dstat_in (eng_dstat[g]),
            .entry_q  (entries_flat[64*g +: 64])
        );
    end

    intredir_rdmux #(
        .NUM_PINS (NUM_PINS),
        .VERSION  (VERSION)
    ) rdmux_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_req       (rd_req),
        .rd_is_sel    (rd_is_sel),
        .rd_is_win    (rd_is_win),
        .sel_q        (sel_q),
        .id_q         (id_q),
        .tsel         (tsel),
        .entries_flat (entries_flat),
        .rdata        (bus_rdata),
        .rvalid       (bus_rvalid)
    );

    AST_SVC_IS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |=> !svc_req || $past(tbl_wr)); // R9

endmodule

// File: tb/intredir_regs_tb_top.sv
// Bench: sweeps the select space of a 24-pin instance and compares with
// a write-merge model; a VERSION 0x11 twin shares the bus.
module intredir_regs_tb_top;

    localparam int NP = 24;
    localparam int AW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          bus_valid = 0, bus_write = 0, bus_word = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [NP-1:0] eng_rirr_set = '0, eng_rirr_clr = '0, eng_dstat = '0;

    logic [31:0]      rdata, rdata11;
    logic             rvalid, rvalid11;
    logic             svc_req, svc11;
    logic             eoi_valid, eoi11;
    logic [7:0]       eoi_vector, eoi_vec11;
    logic [64*NP-1:0] flat, flat11;

    intredir_regs #(.NUM_PINS(NP), .ADDR_W(AW), .VERSION(8'h20)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(rdata), .bus_rvalid(rvalid), .eng_rirr_set(eng_rirr_set),
        .eng_rirr_clr(eng_rirr_clr), .eng_dstat(eng_dstat), .svc_req(svc_req),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .entries_flat(flat));

    intredir_regs #(.NUM_PINS(NP), .ADDR_W(AW), .VERSION(8'h11)) dut_v11_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_word(bus_word), .bus_wdata(bus_wdata),
        .bus_rdata(rdata11), .bus_rvalid(rvalid11), .eng_rirr_set(eng_rirr_set),
        .eng_rirr_clr(eng_rirr_clr), .eng_dstat(eng_dstat), .svc_req(svc11),
        .eoi_valid(eoi11), .eoi_vector(eoi_vec11), .entries_flat(flat11));

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [63:0] exp_e [NP];
    logic cap_svc, cap_eoi, cap_eoi11;
    logic [7:0] cap_vec;
    logic [31:0] rd;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d, input logic w);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_word = w;
        @(negedge clk);
        cap_svc = svc_req; cap_eoi = eoi_valid; cap_vec = eoi_vector; cap_eoi11 = eoi11;
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic w, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a; bus_word = w;
        @(negedge clk);
        d = rdata;
        bus_valid = 0;
    endtask

    // Model of one entry write (R6, R7)
    function automatic logic [63:0] merge(input logic [63:0] old, input logic hi, input logic [31:0] d);
        logic [63:0] n;
        n = hi ? {d, old[31:0]} : {old[63:32], d};
        n[13:12] = old[13:12];
        if (!n[15]) n[13] = 1'b0;
        return n;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10 reset state
        for (int p = 0; p < NP; p++) begin
            exp_e[p] = 64'h0000_0000_0001_0000;
            chk("R10 entry reset", flat[64*p +: 64], exp_e[p]);
        end
        bus_rd(12'h000, 1, rd); chk("R10 select reset", rd, 0);
        bus_rd(12'h010, 1, rd); chk("R10 id reset", rd, 0);

        // R12 / R1: select written through an aliased address
        bus_wr(12'h700, 32'hFFFF_FF5A, 1);
        bus_rd(12'h000, 1, rd); chk("R12 select readback", rd, 32'h5A);
        chk("R9 no svc on select write", cap_svc, 0);
        bus_rd(12'hC00, 1, rd); chk("R1 select alias read", rd, 32'h5A);

        // R3 identification and arbitration
        bus_wr(12'h000, 32'h00, 1);
        bus_wr(12'h010, 32'hFFFF_FFFF, 1);
        chk("R9 no svc on id write", cap_svc, 0);
        bus_rd(12'h010, 1, rd); chk("R3 id read", rd, 32'h0F00_0000);
        bus_wr(12'h000, 32'h02, 1);
        bus_wr(12'h010, 32'h0000_0000, 1);
        bus_rd(12'h010, 1, rd); chk("R3 arb mirrors id, write ignored", rd, 32'h0F00_0000);
        bus_wr(12'h000, 32'h01, 1);
        bus_wr(12'h010, 32'hFFFF_FFFF, 1);
        bus_rd(12'h010, 1, rd); chk("R4 version word", rd, 32'h0017_0020);
        chk("R4 version word v11", rdata11, 32'h0017_0011);
        bus_wr(12'h000, 32'h00, 1);
        bus_rd(12'h010, 1, rd); chk("R3 id after version write", rd, 32'h0F00_0000);

        // R5/R6/R7/R9/R11: sweep every half of every entry
        for (int p = 0; p < NP; p++) begin
            for (int h = 0; h < 2; h++) begin
                logic [31:0] pat;
                pat = 32'h9E37_79B9 * (p * 2 + h + 1);
                bus_wr(12'h000, 32'h10 + p * 2 + h, 1);
                bus_wr(12'h310, pat, 1);
                chk("R9 svc after entry write", cap_svc, 1);
                exp_e[p] = merge(exp_e[p], h[0], pat);
                bus_rd(12'h010, 1, rd);
                chk("R5 half readback", rd, h ? exp_e[p][63:32] : exp_e[p][31:0]);
                chk("R11 flat entry", flat[64*p +: 64], exp_e[p]);
            end
        end

        // R2 narrow window accesses
        bus_wr(12'h000, 32'h14, 1);
        bus_rd(12'h010, 0, rd); chk("R2 narrow read zero", rd, 0);
        bus_wr(12'h010, 32'h0000_0000, 0);
        chk("R2 narrow write no svc", cap_svc, 0);
        chk("R2 narrow write no effect", flat[64*2 +: 64], exp_e[2]);

        // R6/R7 status bits on pin 5
        bus_wr(12'h000, 32'h1A, 1);
        bus_wr(12'h010, 32'h0000_A031, 1);
        exp_e[5] = {exp_e[5][63:32], 32'h0000_8031};
        chk("R6 rirr not written", flat[64*5 +: 64], exp_e[5]);
        @(negedge clk); eng_rirr_set[5] = 1;
        @(negedge clk); eng_rirr_set[5] = 0;
        bus_rd(12'h010, 1, rd); chk("R6 engine sets rirr", rd, 32'h0000_A031);
        bus_wr(12'h010, 32'h0000_8031, 1);
        bus_rd(12'h010, 1, rd); chk("R6 rirr kept over level write", rd, 32'h0000_A031);
        bus_wr(12'h000, 32'h1B, 1);
        bus_wr(12'h010, 32'h1100_0000, 1);
        chk("R6 rirr kept over upper write", flat[64*5 + 13], 1);
        bus_wr(12'h000, 32'h1A, 1);
        bus_wr(12'h010, 32'h0000_2031, 1);
        bus_rd(12'h010, 1, rd); chk("R7 edge write clears rirr", rd, 32'h0000_0031);
        exp_e[5] = 64'h1100_0000_0000_0031;

        // R6 delivery status on pin 7
        eng_dstat[7] = 1;
        bus_wr(12'h000, 32'h1E, 1);
        bus_wr(12'h010, 32'h0000_0000, 1);
        bus_rd(12'h010, 1, rd); chk("R6 dstat survives write", rd, 32'h0000_1000);
        eng_dstat[7] = 0;
        exp_e[7] = {exp_e[7][63:32], 32'h0};
        @(negedge clk);

        // R5 out-of-range index 24 ignores writes
        bus_wr(12'h000, 32'h40, 1);
        bus_wr(12'h010, 32'hFFFF_FFFF, 1);
        chk("R5 out of range no svc", cap_svc, 0);
        for (int p = 0; p < NP; p++)
            chk("R5 entries unchanged", flat[64*p +: 64], exp_e[p]);

        // R5 unused select codes read zero
        for (int s = 3; s < 256; s++) begin
            if (s < 16 || s >= 16 + 2 * NP) begin
                bus_wr(12'h000, 32'(s), 1);
                bus_rd(12'h010, 1, rd); chk("R5 unused select reads zero", rd, 0);
            end
        end

        // R8 end-of-interrupt port
        bus_wr(12'h040, 32'h1234_56C3, 1);
        chk("R8 eoi pulse", cap_eoi, 1);
        chk("R8 eoi vector", cap_vec, 8'hC3);
        chk("R8 no eoi in v11", cap_eoi11, 0);
        @(negedge clk);
        chk("R8 eoi one cycle", eoi_valid, 0);
        bus_wr(12'hF40, 32'h0000_0077, 1);
        chk("R1 eoi alias", cap_vec, 8'h77);
        bus_wr(12'h040, 32'h0000_0011, 0);
        chk("R8 narrow eoi ignored", cap_eoi, 0);
        chk("R9 no svc on eoi", cap_svc, 0);

        finish_run();
    end

endmodule